// File: doc/BRIEF.md
# Auto Mixed-Decay Chopping Sequencer

This block regulates the winding current of one PWM H-bridge by sequencing each chopping cycle. A cycle starts with the bridge driving. After a programmable blanking interval, the current-trip comparator is watched. When it reports that the current has reached the threshold, the bridge leaves the drive phase and begins an off period of programmable length.

At the start of that off period the bridge decays slowly while a second blanking interval runs. When that interval ends, the trip comparator is sampled once more. If the current is still above the threshold, the block switches to fast decay. Otherwise it keeps slow decay for the rest of the off period. Fast decay falls back to slow decay as soon as the current drops below the threshold, or when the zero-current detector fires, so the winding current never reverses. When the off period ends, a new drive phase begins, again with blanking.

The block is controlled by a synchronous enable. Lengths are given in clock cycles on two configuration inputs. These inputs are read when a timer is loaded, so they should only be changed while the block is disabled.

Top module: `decay_chopper`

## Requirements
- R1: After reset, `phase_o` is 2'b00 (off) and `trip_pulse_o` is 0.
- R2: With `en` low at a clock edge, `phase_o` is 2'b00 after that edge. From the off state with `en` high, `phase_o` becomes 2'b01 (drive) after the next edge.
- R3: During the first `blank_cyc` cycles of every drive phase, `trip_i` is ignored and the phase stays 2'b01.
- R4: In any later drive cycle, `trip_i` high moves the phase to 2'b11 after the edge. `trip_pulse_o` is high in that first off cycle only.
- R5: The first `blank_cyc` + 1 cycles of each off phase show 2'b11, and `trip_i` is ignored during that time. The code 2'b10 never follows 2'b01 directly.
- R6: If `trip_i` is low in off cycle `blank_cyc` + 1, the phase stays 2'b11 until the off time ends.
- R7: If `trip_i` is high in off cycle `blank_cyc` + 1, the phase becomes 2'b10 (fast decay).
- R8: During fast decay, `trip_i` low moves the phase to 2'b11 after the edge.
- R9: During fast decay, `zero_i` high moves the phase to 2'b11 after the edge.
- R10: Each off phase (2'b10 or 2'b11) lasts exactly `toff_cyc` cycles, counted from the trip, and is followed by drive (2'b01).
- R11: Once slow decay follows a fast-decay or blanking decision, the phase does not return to 2'b10 within the same off phase.
- R12: `trip_pulse_o` is high for exactly one cycle per chopping cycle, and for arbitrary input sequences the phase obeys R2 to R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable; low forces the off state |
| trip_i | input | 1 | Current at or above the trip threshold |
| zero_i | input | 1 | Zero-current detector output |
| blank_cyc | input | CNT_W | Blanking length in cycles |
| toff_cyc | input | CNT_W | Off-time length in cycles (greater than `blank_cyc`) |
| phase_o | output | 2 | 00 off, 01 drive, 10 fast decay, 11 slow decay |
| trip_pulse_o | output | 1 | One-cycle pulse in the first off cycle |

## Verification
The bench holds `trip_i` high from the very first drive cycle. A design that samples during blanking would then trip too early. It also holds the trip input high through the blanking at the start of decay. A design that decides too soon would then jump to fast decay before the blanking has run out. Other tests drop the trip input during fast decay, and raise `zero_i` during fast decay. A design that missed either case would keep the current in fast decay and let it reverse. The bench measures the length of every off phase, which exposes off-by-one errors in the off-time counter. Random trip, zero and enable patterns then run against a cycle model built from the requirements.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_DRIVE,
    ST_DBLANK,
    ST_FAST,
    ST_SLOW
  } chop_state_t;

  localparam logic [1:0] PH_OFF   = 2'b00;
  localparam logic [1:0] PH_DRIVE = 2'b01;
  localparam logic [1:0] PH_FAST  = 2'b10;
  localparam logic [1:0] PH_SLOW  = 2'b11;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             cnt_zero_o,
  output logic             cnt_one_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = load_i | (dec_i & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) cnt_d = val_i;
    else if (dec_i && cnt_q != '0) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_one_o  = (cnt_q == ONE);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        trip_i,
  input  logic        zero_i,
  input  logic        blank_done_i,
  input  logic        off_last_i,
  output chop_state_t state_o,
  output logic        ld_blank_o,
  output logic        ld_off_o,
  output logic        trip_evt_o
);
  chop_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    ld_blank_o = 1'b0;
    ld_off_o   = 1'b0;
    trip_evt_o = 1'b0;
    if (!en) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d       = ST_DRIVE;
          ld_blank_o = 1'b1;
        end
        ST_DRIVE: begin
          if (blank_done_i && trip_i) begin
            st_d       = ST_DBLANK;
            ld_blank_o = 1'b1;
            ld_off_o   = 1'b1;
            trip_evt_o = 1'b1;
          end
        end
        ST_DBLANK: begin
          if (off_last_i) begin
            st_d       = ST_DRIVE;
            ld_blank_o = 1'b1;
          end else if (blank_done_i) begin
            st_d = trip_i ? ST_FAST : ST_SLOW;
          end
        end
        ST_FAST: begin
          if (off_last_i) begin
            st_d       = ST_DRIVE;
            ld_blank_o = 1'b1;
          end else if (zero_i || !trip_i) begin
            st_d = ST_SLOW;
          end
        end
        ST_SLOW: begin
          if (off_last_i) begin
            st_d       = ST_DRIVE;
            ld_blank_o = 1'b1;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/decay_chopper.sv
module decay_chopper
  import chop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trip_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] blank_cyc,
  input  logic [CNT_W-1:0] toff_cyc,
  output logic [1:0]       phase_o,
  output logic             trip_pulse_o
);
  chop_state_t state;
  logic ld_blank, ld_off, trip_evt;
  logic blank_zero, blank_one_unused, off_zero_unused, off_one;
  logic blank_run, off_run;
  logic pulse_q;

  assign blank_run = (state == ST_DRIVE) || (state == ST_DBLANK);
  assign off_run   = (state == ST_DBLANK) || (state == ST_FAST) || (state == ST_SLOW);

  chop_timer #(.CNT_W(CNT_W)) u_blank_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_blank),
    .val_i      (blank_cyc),
    .dec_i      (blank_run),
    .cnt_zero_o (blank_zero),
    .cnt_one_o  (blank_one_unused)
  );

  chop_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld_off),
    .val_i      (toff_cyc),
    .dec_i      (off_run),
    .cnt_zero_o (off_zero_unused),
    .cnt_one_o  (off_one)
  );

  chop_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .trip_i       (trip_i),
    .zero_i       (zero_i),
    .blank_done_i (blank_zero),
    .off_last_i   (off_one),
    .state_o      (state),
    .ld_blank_o   (ld_blank),
    .ld_off_o     (ld_off),
    .trip_evt_o   (trip_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else pulse_q <= trip_evt;
  end

  always_comb begin
    unique case (state)
      ST_DRIVE:            phase_o = PH_DRIVE;
      ST_FAST:             phase_o = PH_FAST;
      ST_DBLANK, ST_SLOW:  phase_o = PH_SLOW;
      default:             phase_o = PH_OFF;
    endcase
  end

  assign trip_pulse_o = pulse_q;
endmodule

// File: rtl/decay_chopper_chk.sv
module decay_chopper_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             trip_i,
  input logic             zero_i,
  input logic [CNT_W-1:0] toff_cyc,
  input logic [1:0]       phase_o,
  input logic             trip_pulse_o
);
  logic [CNT_W:0] dk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dk_run <= '0;
    else if (phase_o[1]) dk_run <= dk_run + 1'b1;
    else dk_run <= '0;
  end

  assert_off_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> phase_o == 2'b00);
  assert_wake_to_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b00 && en) |=> phase_o == 2'b01);
  assert_pulse_at_decay_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse_o |-> (phase_o == 2'b11 && $past(phase_o) == 2'b01));
  assert_no_fast_after_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 2'b01 |=> phase_o != 2'b10);
  assert_fast_ends_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b10 && !trip_i && en) |=> phase_o != 2'b10);
  assert_fast_ends_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b10 && zero_i && en) |=> phase_o != 2'b10);
  assert_off_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o[1] && en) |-> dk_run < {1'b0, toff_cyc});
  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse_o |=> !trip_pulse_o);
endmodule

bind decay_chopper decay_chopper_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en),
  .trip_i       (trip_i),
  .zero_i       (zero_i),
  .toff_cyc     (toff_cyc),
  .phase_o      (phase_o),
  .trip_pulse_o (trip_pulse_o)
);

// File: tb/decay_chopper_bench.sv
module decay_chopper_bench;
  localparam int CNT_W = 8;
  localparam int S_OFF = 0, S_DRV = 1, S_DBL = 2, S_FST = 3, S_SLW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, trip_i = 1'b0, zero_i = 1'b0;
  logic [CNT_W-1:0] blank_cyc = 8'd3, toff_cyc = 8'd10;
  logic [1:0] phase_o;
  logic trip_pulse_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_st = S_OFF, m_b = 0, m_o = 0;
  bit m_pulse = 1'b0;

  always #5 clk = ~clk;

  decay_chopper #(.CNT_W(CNT_W)) u_decay_chopper (
    .clk(clk), .rst_n(rst_n), .en(en), .trip_i(trip_i), .zero_i(zero_i),
    .blank_cyc(blank_cyc), .toff_cyc(toff_cyc),
    .phase_o(phase_o), .trip_pulse_o(trip_pulse_o)
  );

  function automatic logic [1:0] ph_of(input int s);
    case (s)
      S_DRV: return 2'b01;
      S_FST: return 2'b10;
      S_DBL, S_SLW: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // Reference step built from R2..R11
  task automatic model_step(input bit e, input bit t, input bit z);
    int ns = m_st, nb = m_b, no = m_o;
    bit lb = 0, lo = 0, p = 0;
    if (!e) ns = S_OFF;
    else case (m_st)
      S_OFF: begin ns = S_DRV; lb = 1; end
      S_DRV: if (m_b == 0 && t) begin ns = S_DBL; lb = 1; lo = 1; p = 1; end
      S_DBL: if (m_o == 1) begin ns = S_DRV; lb = 1; end
             else if (m_b == 0) ns = t ? S_FST : S_SLW;
      S_FST: if (m_o == 1) begin ns = S_DRV; lb = 1; end
             else if (z || !t) ns = S_SLW;
      default: if (m_o == 1) begin ns = S_DRV; lb = 1; end
    endcase
    if (lb) nb = int'(blank_cyc);
    else if ((m_st == S_DRV || m_st == S_DBL) && m_b != 0) nb = m_b - 1;
    if (lo) no = int'(toff_cyc);
    else if ((m_st == S_DBL || m_st == S_FST || m_st == S_SLW) && m_o != 0) no = m_o - 1;
    m_st = ns; m_b = nb; m_o = no; m_pulse = p;
  endtask

  task automatic check(input string tag, input logic [1:0] eph, input bit ep);
    checks++;
    if (phase_o !== eph || trip_pulse_o !== ep) begin
      errors++;
      $display("FAIL %s phase=%b exp=%b pulse=%b exp=%b", tag, phase_o, eph, trip_pulse_o, ep);
    end
  endtask

  task automatic cyc(input bit e, input bit t, input bit z, input string tag);
    @(negedge clk);
    en = e; trip_i = t; zero_i = z;
    model_step(e, t, z);
    @(posedge clk);
    #1;
    check(tag, ph_of(m_st), m_pulse);
  endtask

  int dk;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 2'b00, 1'b0);

    // chop 1: trip held from start, fast decay, trip drops
    cyc(1, 1, 0, "R2");
    repeat (3) cyc(1, 1, 0, "R3");
    cyc(1, 1, 0, "R4");
    dk = 1;
    repeat (3) begin cyc(1, 1, 0, "R5"); dk++; end
    cyc(1, 1, 0, "R7"); dk++;
    cyc(1, 1, 0, "R7"); dk++;
    cyc(1, 0, 0, "R8"); dk++;
    while (m_st != S_DRV) begin
      cyc(1, 1, 0, "R11");
      if (phase_o[1]) dk++;
    end
    checks++;
    if (dk != 10) begin
      errors++;
      $display("FAIL R10 decay cycles=%0d exp=%0d", dk, 10);
    end

    // chop 2: current low at end of decay blanking
    repeat (3) cyc(1, 0, 0, "R3");
    cyc(1, 0, 0, "R4");
    cyc(1, 1, 0, "R4");
    repeat (3) cyc(1, 0, 0, "R5");
    cyc(1, 0, 0, "R6");
    while (m_st != S_DRV) cyc(1, 1, 0, "R11");
    cyc(1, 0, 0, "R10");

    // chop 3: zero current during fast decay
    repeat (2) cyc(1, 1, 0, "R3");
    cyc(1, 1, 0, "R4");
    repeat (3) cyc(1, 1, 0, "R5");
    cyc(1, 1, 0, "R7");
    cyc(1, 1, 1, "R9");
    cyc(1, 1, 0, "R11");
    cyc(0, 1, 0, "R2");
    cyc(0, 1, 0, "R2");

    // short blanking, short off time
    blank_cyc = 8'd0; toff_cyc = 8'd1;
    cyc(1, 1, 0, "R2");
    cyc(1, 1, 0, "R4");
    cyc(1, 1, 0, "R10");
    cyc(0, 0, 0, "R2");

    // random run
    for (int i = 0; i < 6000; i++) begin
      bit e, t, z;
      e = ($urandom_range(0, 99) > 2);
      if (!e) begin
        @(negedge clk);
        blank_cyc = 8'($urandom_range(0, 5));
        toff_cyc  = blank_cyc + 8'($urandom_range(1, 12));
        en = 1'b0;
        model_step(1'b0, trip_i, zero_i);
        @(posedge clk);
        #1;
        check("R12", ph_of(m_st), m_pulse);
      end else begin
        t = ($urandom_range(0, 99) < 60);
        z = ($urandom_range(0, 99) < 10);
        cyc(1'b1, t, z, "R12");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule